// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether a slave on an I2C bus is being addressed. A front end that samples the bus and assembles bytes passes each received byte with a one-cycle valid strobe. It also pulses separate indications for START, repeated START and STOP. The matcher uses these and a set of static configuration fields to decide on a match.

The block supports plain 7-bit addressing and 10-bit addressing. In 10-bit mode, a prefix byte is followed by a low address byte. The block recognises the general call, and it can optionally accept a whole band of 7-bit addresses above the primary one. After a 10-bit write match, a repeated START followed by the read-direction prefix re-selects the slave on that prefix alone. The outputs are registered: a match flag, a general-call flag and the captured direction bit. Both flags stay set until the next START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: With `ten_bit_i`=0, when bits [7:1] of the first byte after START equal `own_addr_i[6:0]` (address nonzero), `match_o` goes to 1 in the cycle after that byte's strobe.
- R2: A first byte equal to 0x00 sets both `match_o` and `gcall_o` when `gc_en_i`=1. When `gc_en_i`=0 it sets neither, and address 0 is never matched through the primary or the band compare.
- R3: With `band_en_i`=1 in 7-bit mode, a 7-bit address A matches when `own_addr_i[6:0]` < A and A <= `band_top_i`, with both compares unsigned.
- R4: With `band_en_i`=0, an address strictly inside the band does not match, while the exact primary address still does.
- R5: With `ten_bit_i`=1, a first byte of binary 11110 followed by `hi_addr_i[1:0]` and a 0 direction bit, then a second byte equal to `own_addr_i[7:0]`, sets `match_o` one cycle after the second strobe. `match_o` stays 0 after the first byte alone, and there is no match if `hi_addr_i[2]`=1. In 10-bit mode, 7-bit and band compares are off.
- R6: In 7-bit mode, `hi_addr_i` and `own_addr_i[7]` have no effect on the decision.
- R7: After a completed 10-bit write match, a repeated START followed by the prefix byte with direction bit 1 sets `match_o`=1 and `rw_o`=1 without a low byte. The same prefix with no earlier 10-bit match gives no match.
- R8: STOP clears `match_o`, `gcall_o` and the pending 10-bit state from the next cycle on. START clears `match_o` and `gcall_o` from the next cycle on.
- R9: Once the decision for a transfer is made, further bytes leave `match_o`, `gcall_o` and `rw_o` unchanged until the next START or STOP.
- R10: A byte strobed in the same cycle as START is discarded. STOP in the same cycle as START wins, so the pending 10-bit state is dropped.
- R11: After reset, `match_o`, `gcall_o` and `rw_o` are 0. `rw_o` takes bit 0 of each first byte after START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen, one-cycle pulse |
| stop_i | input | 1 | STOP seen, one-cycle pulse |
| byte_vld_i | input | 1 | Received byte valid, one-cycle pulse |
| byte_i | input | 8 | Received byte |
| gc_en_i | input | 1 | General call enable |
| ten_bit_i | input | 1 | 0: 7-bit scheme, 1: 10-bit scheme |
| hi_addr_i | input | 3 | Upper address bits for 10-bit scheme |
| own_addr_i | input | 8 | Primary address; [6:0] in 7-bit, low byte in 10-bit |
| band_en_i | input | 1 | Band match enable |
| band_top_i | input | 7 | Inclusive upper bound of the band |
| match_o | output | 1 | Slave addressed |
| gcall_o | output | 1 | Addressed by general call |
| rw_o | output | 1 | Captured direction bit, 1 = read |

## Verification
A byte strobe can land in the same cycle as START, and START can land in the same cycle as STOP. The bench drives these pairs on one clock edge. First it presents a byte that would match together with START, and checks that no match appears until the same byte is sent again alone. Then it completes a 10-bit write match, pulses STOP and START together, sends the read prefix, and expects no match because the pending 10-bit state must be gone.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int A7_W = 7;
  localparam int LO_W = 8;
  localparam int HI_W = 3;
  localparam logic [4:0] TEN_PFX = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_LOW,
    ST_HOLD
  } seq_e;
endpackage

// File: rtl/i2c_am_byte_dec.sv
module i2c_am_byte_dec
  import i2c_am_pkg::*;
#(
  parameter bit HAS_BAND = 1'b1
) (
  input  logic [LO_W-1:0] byte_i,
  input  logic            gc_en_i,
  input  logic            ten_bit_i,
  input  logic [HI_W-1:0] hi_addr_i,
  input  logic [LO_W-1:0] own_addr_i,
  input  logic            band_en_i,
  input  logic [A7_W-1:0] band_top_i,
  output logic            hit7_o,
  output logic            gc_hit_o,
  output logic            pfx_w_o,
  output logic            pfx_r_o,
  output logic            lo_hit_o
);
  logic [A7_W-1:0] a7;
  logic            a7_zero;
  logic            exact7;
  logic            in_band;
  logic            pfx_ok;

  assign a7      = byte_i[LO_W-1:1];
  assign a7_zero = (a7 == '0);
  assign exact7  = (a7 == own_addr_i[A7_W-1:0]);

  generate
    if (HAS_BAND) begin : g_band
      assign in_band = band_en_i && (a7 > own_addr_i[A7_W-1:0]) && (a7 <= band_top_i);
    end else begin : g_noband
      logic unused_band;
      assign unused_band = band_en_i ^ (^band_top_i);
      assign in_band = 1'b0;
    end
  endgenerate

  assign hit7_o   = !ten_bit_i && !a7_zero && (exact7 || in_band);
  assign gc_hit_o = gc_en_i && (byte_i == '0);

  // prefix: 11110 + two upper bits; a set third bit is unreachable
  assign pfx_ok   = ten_bit_i && (byte_i[7:3] == TEN_PFX) &&
                    (byte_i[2:1] == hi_addr_i[1:0]) && !hi_addr_i[2];
  assign pfx_w_o  = pfx_ok && !byte_i[0];
  assign pfx_r_o  = pfx_ok && byte_i[0];
  assign lo_hit_o = (byte_i == own_addr_i);
endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
  import i2c_am_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic byte_vld_i,
  input  logic rw_bit_i,
  input  logic ten_bit_i,
  input  logic hit7_i,
  input  logic gc_hit_i,
  input  logic pfx_w_i,
  input  logic pfx_r_i,
  input  logic lo_hit_i,
  output logic match_o,
  output logic gcall_o,
  output logic rw_o
);
  seq_e state_q, state_d;
  logic match_q, match_d;
  logic gc_q, gc_d;
  logic rw_q, rw_d;
  logic armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    match_d = match_q;
    gc_d    = gc_q;
    rw_d    = rw_q;
    armed_d = armed_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      match_d = 1'b0;
      gc_d    = 1'b0;
      armed_d = 1'b0;
    end else if (start_i) begin
      // a byte in the same cycle is dropped
      state_d = ST_FIRST;
      match_d = 1'b0;
      gc_d    = 1'b0;
    end else if (byte_vld_i) begin
      unique case (state_q)
        ST_FIRST: begin
          rw_d    = rw_bit_i;
          armed_d = 1'b0;
          state_d = ST_HOLD;
          if (gc_hit_i) begin
            match_d = 1'b1;
            gc_d    = 1'b1;
          end else if (ten_bit_i) begin
            if (pfx_w_i) begin
              state_d = ST_LOW;
            end else if (pfx_r_i && armed_q) begin
              match_d = 1'b1;
              armed_d = 1'b1;
            end
          end else begin
            match_d = hit7_i;
          end
        end
        ST_LOW: begin
          match_d = lo_hit_i;
          armed_d = lo_hit_i;
          state_d = ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      match_q <= 1'b0;
      gc_q    <= 1'b0;
      rw_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      match_q <= match_d;
      gc_q    <= gc_d;
      rw_q    <= rw_d;
      armed_q <= armed_d;
    end
  end

  assign match_o = match_q;
  assign gcall_o = gc_q;
  assign rw_o    = rw_q;

  p_gc_in_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcall_o |-> match_o);
  p_stop_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!match_o && !gcall_o));
  p_start_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !match_o);
  p_rise_on_byte_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> ($past(byte_vld_i) && !$past(start_i) && !$past(stop_i)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !start_i && !stop_i) |=> match_o);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter bit HAS_BAND = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            byte_vld_i,
  input  logic [LO_W-1:0] byte_i,
  input  logic            gc_en_i,
  input  logic            ten_bit_i,
  input  logic [HI_W-1:0] hi_addr_i,
  input  logic [LO_W-1:0] own_addr_i,
  input  logic            band_en_i,
  input  logic [A7_W-1:0] band_top_i,
  output logic            match_o,
  output logic            gcall_o,
  output logic            rw_o
);
  logic hit7, gc_hit, pfx_w, pfx_r, lo_hit;

  i2c_am_byte_dec #(.HAS_BAND(HAS_BAND)) u_dec (
    .byte_i     (byte_i),
    .gc_en_i    (gc_en_i),
    .ten_bit_i  (ten_bit_i),
    .hi_addr_i  (hi_addr_i),
    .own_addr_i (own_addr_i),
    .band_en_i  (band_en_i),
    .band_top_i (band_top_i),
    .hit7_o     (hit7),
    .gc_hit_o   (gc_hit),
    .pfx_w_o    (pfx_w),
    .pfx_r_o    (pfx_r),
    .lo_hit_o   (lo_hit)
  );

  i2c_am_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .rw_bit_i   (byte_i[0]),
    .ten_bit_i  (ten_bit_i),
    .hit7_i     (hit7),
    .gc_hit_i   (gc_hit),
    .pfx_w_i    (pfx_w),
    .pfx_r_i    (pfx_r),
    .lo_hit_i   (lo_hit),
    .match_o    (match_o),
    .gcall_o    (gcall_o),
    .rw_o       (rw_o)
  );
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  localparam int CLK_P = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [3:0] req;
    logic       ten, gc, band;
    logic [2:0] hi;
    logic [7:0] own;
    logic [6:0] top;
    logic [1:0] nb;
    logic [7:0] b0, b1;
    logic       em, eg, er;
  } vec_t;

  // req ten gc band hi own top nb b0 b1 em eg er
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0,1'b0,1'b0,3'd0,8'h3A,7'h40,2'd1,8'h74,8'h00,1'b1,1'b0,1'b0}, // R1 exact write
    '{4'd1,  1'b0,1'b0,1'b0,3'd0,8'h3A,7'h40,2'd1,8'h75,8'h00,1'b1,1'b0,1'b1}, // R1 exact read
    '{4'd4,  1'b0,1'b0,1'b0,3'd0,8'h3A,7'h40,2'd1,8'h76,8'h00,1'b0,1'b0,1'b0}, // R4 in band, off
    '{4'd3,  1'b0,1'b0,1'b1,3'd0,8'h3A,7'h40,2'd1,8'h76,8'h00,1'b1,1'b0,1'b0}, // R3 in band
    '{4'd3,  1'b0,1'b0,1'b1,3'd0,8'h3A,7'h40,2'd1,8'h80,8'h00,1'b1,1'b0,1'b0}, // R3 top inclusive
    '{4'd3,  1'b0,1'b0,1'b1,3'd0,8'h3A,7'h40,2'd1,8'h82,8'h00,1'b0,1'b0,1'b0}, // R3 above top
    '{4'd3,  1'b0,1'b0,1'b1,3'd0,8'h3A,7'h40,2'd1,8'h72,8'h00,1'b0,1'b0,1'b0}, // R3 below own
    '{4'd2,  1'b0,1'b1,1'b0,3'd0,8'h3A,7'h40,2'd1,8'h00,8'h00,1'b1,1'b1,1'b0}, // R2 gc on
    '{4'd2,  1'b0,1'b0,1'b1,3'd0,8'h00,7'h40,2'd1,8'h00,8'h00,1'b0,1'b0,1'b0}, // R2 gc off, own=0
    '{4'd6,  1'b0,1'b0,1'b0,3'd7,8'hBA,7'h40,2'd1,8'h74,8'h00,1'b1,1'b0,1'b0}, // R6 hi/own[7] ignored
    '{4'd5,  1'b1,1'b0,1'b0,3'd2,8'h5C,7'h40,2'd2,8'hF4,8'h5C,1'b1,1'b0,1'b0}, // R5 10-bit hit
    '{4'd5,  1'b1,1'b0,1'b0,3'd2,8'h5C,7'h40,2'd2,8'hF4,8'h5D,1'b0,1'b0,1'b0}, // R5 low miss
    '{4'd5,  1'b1,1'b0,1'b0,3'd2,8'h5C,7'h40,2'd2,8'hF2,8'h5C,1'b0,1'b0,1'b0}, // R5 prefix miss
    '{4'd5,  1'b1,1'b0,1'b0,3'd6,8'h5C,7'h40,2'd2,8'hF4,8'h5C,1'b0,1'b0,1'b0}, // R5 hi[2] set
    '{4'd2,  1'b1,1'b1,1'b0,3'd2,8'h5C,7'h40,2'd1,8'h00,8'h00,1'b1,1'b1,1'b0}, // R2 gc in 10-bit
    '{4'd5,  1'b1,1'b0,1'b1,3'd2,8'h3A,7'h40,2'd1,8'h74,8'h00,1'b0,1'b0,1'b0}  // R5 no 7-bit in 10-bit
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, bvld = 1'b0;
  logic [7:0] bdat = '0;
  logic gc_en = 1'b0, ten = 1'b0, band = 1'b0;
  logic [2:0] hi = '0;
  logic [7:0] own = '0;
  logic [6:0] top = '0;
  logic match, gcall, rw;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_addr_match u_i2c_addr_match (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_vld_i(bvld), .byte_i(bdat), .gc_en_i(gc_en), .ten_bit_i(ten),
    .hi_addr_i(hi), .own_addr_i(own), .band_en_i(band), .band_top_i(top),
    .match_o(match), .gcall_o(gcall), .rw_o(rw)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%b exp=%b", req, what, got, exp);
    end
  endtask

  // each pulse: drive at negedge, captured at next posedge, returns at following negedge
  task automatic pulse(input logic s, input logic p, input logic v, input logic [7:0] d);
    @(negedge clk);
    start = s; stop = p; bvld = v; bdat = d;
    @(negedge clk);
    start = 1'b0; stop = 1'b0; bvld = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    pulse(1'b0, 1'b0, 1'b1, d);
  endtask

  task automatic new_xfer();
    pulse(1'b0, 1'b1, 1'b0, 8'h00);
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic cfg(input logic t, input logic g, input logic b, input logic [2:0] h,
                     input logic [7:0] o, input logic [6:0] tp);
    ten = t; gc_en = g; band = b; hi = h; own = o; top = tp;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "match after reset", match, 1'b0);
    chk("R11", "gcall after reset", gcall, 1'b0);
    chk("R11", "rw after reset", rw, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cfg(VECS[i].ten, VECS[i].gc, VECS[i].band, VECS[i].hi, VECS[i].own, VECS[i].top);
      new_xfer();
      send(VECS[i].b0);
      if (VECS[i].nb == 2'd2) send(VECS[i].b1);
      total++;
      if (match !== VECS[i].em || gcall !== VECS[i].eg || rw !== VECS[i].er) begin
        bad++;
        $display("FAIL R%0d vec %0d: got=%b%b%b exp=%b%b%b", VECS[i].req, i,
                 match, gcall, rw, VECS[i].em, VECS[i].eg, VECS[i].er);
      end
    end

    // R5: no match after the prefix alone
    cfg(1'b1, 1'b0, 1'b0, 3'd2, 8'h5C, 7'h40);
    new_xfer();
    send(8'hF4);
    chk("R5", "match after prefix only", match, 1'b0);
    send(8'h5C);
    chk("R5", "match after low byte", match, 1'b1);
    // R8 start clears
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R8", "match after start", match, 1'b0);
    // R7 repeated start read
    send(8'hF5);
    chk("R7", "match on read prefix", match, 1'b1);
    chk("R7", "rw on read prefix", rw, 1'b1);

    // R7 read prefix with no earlier write match
    new_xfer();
    send(8'hF5);
    chk("R7", "read prefix without write match", match, 1'b0);

    // R8 stop clears match and gcall
    cfg(1'b0, 1'b1, 1'b0, 3'd0, 8'h3A, 7'h40);
    new_xfer();
    send(8'h00);
    chk("R2", "gcall set", gcall, 1'b1);
    pulse(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8", "match after stop", match, 1'b0);
    chk("R8", "gcall after stop", gcall, 1'b0);

    // R9 trailing bytes ignored
    pulse(1'b1, 1'b0, 1'b0, 8'h00);
    send(8'h74);
    send(8'h00);
    send(8'h03);
    chk("R9", "match held", match, 1'b1);
    chk("R9", "gcall unchanged", gcall, 1'b0);
    chk("R9", "rw unchanged", rw, 1'b0);

    // R10 byte with start discarded
    pulse(1'b0, 1'b1, 1'b0, 8'h00);
    pulse(1'b1, 1'b0, 1'b1, 8'h74);
    chk("R10", "byte with start", match, 1'b0);
    send(8'h74);
    chk("R10", "first byte after start", match, 1'b1);

    // R10 stop+start together drops pending 10-bit state
    cfg(1'b1, 1'b0, 1'b0, 3'd2, 8'h5C, 7'h40);
    new_xfer();
    send(8'hF4);
    send(8'h5C);
    chk("R5", "10-bit write match", match, 1'b1);
    pulse(1'b1, 1'b1, 1'b0, 8'h00);
    send(8'hF5);
    chk("R10", "read prefix after stop+start", match, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule